// File: doc/BRIEF.md
# Three-Stage Pipeline Stall Controller

This block is the control path of a small in-order pipeline that has three stages: instruction fetch, operand fetch and execute. Each stage holds a valid bit, an instruction tag and a latency count. An instruction enters through a ready/valid handshake. It moves one stage per clock while execute is free, and it retires from execute with a one-cycle pulse that carries its tag.

An instruction may be marked multi-cycle with a latency of 1 to `MAX_LAT` cycles. While such an instruction sits in execute, the controller raises `busy` and freezes the operand-fetch and fetch stages. The stall lasts for the instruction's full latency, whether or not the instruction behind it needs its result. Execute never holds more than one instruction. A flush input empties the two front stages and lets the instruction in execute finish.

Top module: `pipe3_stall_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all three stages. In the cycle after a reset edge, `busy` and `ret_valid` are 0 and `in_ready` is 1.
- R2: An instruction is taken in on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in every cycle where `busy` is 1 and in every cycle where `flush` is 1, and 1 otherwise.
- R3: A single-cycle instruction accepted at edge a retires (`ret_valid`=1, `ret_tag` = its tag) in the cycle that follows edge a+2. Back-to-back single-cycle instructions retire one per cycle.
- R4: A multi-cycle instruction (`in_multi`=1) with latency L makes `busy` high for exactly L-1 consecutive cycles once it enters execute, and retires in the L-th cycle, L+1 cycles after its accept edge. `busy` and `ret_valid` are never high together.
- R5: The latency field is ignored when `in_multi`=0, and the instruction takes 1 cycle. A latency of 0 with `in_multi`=1 counts as 1. A latency above `MAX_LAT` is saturated to `MAX_LAT`.
- R6: The instruction behind a multi-cycle instruction waits in operand fetch even when it is independent of that instruction. It retires in the cycle directly after the multi-cycle instruction retires.
- R7: A `flush` seen at a rising edge invalidates fetch and operand fetch, and an instruction offered in that cycle is not taken. An instruction already in execute keeps its timing and retires. A flush while execute is not busy leaves execute empty in the next cycle.
- R8: Every accepted, unflushed instruction retires exactly once, and the retirements follow acceptance order. `ret_tag` holds steady while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new instruction is offered |
| in_ready | output | 1 | Controller takes the offered instruction at this edge |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_multi | input | 1 | Offered instruction is multi-cycle |
| in_lat | input | $clog2(MAX_LAT+1) | Latency in cycles of a multi-cycle instruction |
| flush | input | 1 | Invalidate fetch and operand-fetch stages |
| busy | output | 1 | Execute holds a multi-cycle instruction that is not yet in its last cycle |
| ret_valid | output | 1 | An instruction retires in this cycle |
| ret_tag | output | TAG_W | Tag of the instruction in execute |

## Verification
The hardest state to reach is a full pipeline: a multi-cycle instruction in execute, an independent instruction held in operand fetch, and a third held in fetch, with a flush landing while the stall lasts. The bench reaches it by issuing a multi-cycle instruction and then two single-cycle ones back to back. The third is accepted in the last cycle before `busy` rises, so all three stages fill. A one-cycle flush then hits during the stall. The bench checks the exact retire cycle of the executing instruction, and it checks that neither frozen instruction ever retires.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    // Occupancy of the execute stage as seen by the rest of the controller.
    typedef enum logic [1:0] {
        EX_EMPTY = 2'd0,
        EX_BUSY  = 2'd1,
        EX_LAST  = 2'd2
    } ex_state_e;

endpackage

// File: rtl/pipe3_front.sv
module pipe3_front
    import pipe3_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int MAX_LAT = 64,
    localparam int CNT_W  = $clog2(MAX_LAT),
    localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_multi,
    input  logic [LAT_W-1:0] in_lat,
    output logic             in_ready,
    output logic             of_vld,
    output logic [TAG_W-1:0] of_tag,
    output logic [CNT_W-1:0] of_cnt
);

    typedef struct packed {
        logic             if_vld;
        logic [TAG_W-1:0] if_tag;
        logic [CNT_W-1:0] if_cnt;
        logic             of_vld;
        logic [TAG_W-1:0] of_tag;
        logic [CNT_W-1:0] of_cnt;
    } front_t;

    front_t           front_d, front_q;
    logic [LAT_W-1:0] lat_eff;

    always_comb begin
        front_d  = front_q;
        in_ready = advance && !flush;

        // Normalise the latency once, at entry: 1..MAX_LAT.
        if (!in_multi || in_lat == '0) begin
            lat_eff = LAT_W'(1);
        end else if (in_lat > LAT_W'(MAX_LAT)) begin
            lat_eff = LAT_W'(MAX_LAT);
        end else begin
            lat_eff = in_lat;
        end

        if (advance) begin
            front_d.of_vld = front_q.if_vld;
            front_d.of_tag = front_q.if_tag;
            front_d.of_cnt = front_q.if_cnt;
            front_d.if_vld = in_valid && in_ready;
            front_d.if_tag = in_tag;
            front_d.if_cnt = CNT_W'(lat_eff - LAT_W'(1));
        end

        if (flush) begin
            front_d.if_vld = 1'b0;
            front_d.of_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    assign of_vld = front_q.of_vld;
    assign of_tag = front_q.of_tag;
    assign of_cnt = front_q.of_cnt;

endmodule

// File: rtl/pipe3_exec.sv
module pipe3_exec
    import pipe3_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int MAX_LAT = 64,
    localparam int CNT_W  = $clog2(MAX_LAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             of_vld,
    input  logic [TAG_W-1:0] of_tag,
    input  logic [CNT_W-1:0] of_cnt,
    output ex_state_e        ex_state,
    output logic [TAG_W-1:0] ex_tag
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
    } ex_t;

    ex_t ex_d, ex_q;

    always_comb begin
        if (!ex_q.vld) begin
            ex_state = EX_EMPTY;
        end else if (ex_q.cnt != '0) begin
            ex_state = EX_BUSY;
        end else begin
            ex_state = EX_LAST;
        end

        ex_d = ex_q;
        if (ex_state == EX_BUSY) begin
            ex_d.cnt = ex_q.cnt - CNT_W'(1);
        end else begin
            ex_d.vld = of_vld && !flush;
            ex_d.tag = of_tag;
            ex_d.cnt = of_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    assign ex_tag = ex_q.tag;

endmodule

// File: rtl/pipe3_stall_ctrl.sv
module pipe3_stall_ctrl
    import pipe3_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int MAX_LAT = 64,
    localparam int CNT_W  = $clog2(MAX_LAT),
    localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_multi,
    input  logic [LAT_W-1:0] in_lat,
    input  logic             flush,
    output logic             busy,
    output logic             ret_valid,
    output logic [TAG_W-1:0] ret_tag
);

    ex_state_e        ex_state;
    logic             advance;
    logic             of_vld;
    logic [TAG_W-1:0] of_tag;
    logic [CNT_W-1:0] of_cnt;

    assign advance   = (ex_state != EX_BUSY);
    assign busy      = (ex_state == EX_BUSY);
    assign ret_valid = (ex_state == EX_LAST);

    pipe3_front #(
        .TAG_W   (TAG_W),
        .MAX_LAT (MAX_LAT)
    ) u_front (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .flush    (flush),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .in_multi (in_multi),
        .in_lat   (in_lat),
        .in_ready (in_ready),
        .of_vld   (of_vld),
        .of_tag   (of_tag),
        .of_cnt   (of_cnt)
    );

    pipe3_exec #(
        .TAG_W   (TAG_W),
        .MAX_LAT (MAX_LAT)
    ) u_exec (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .of_vld   (of_vld),
        .of_tag   (of_tag),
        .of_cnt   (of_cnt),
        .ex_state (ex_state),
        .ex_tag   (ret_tag)
    );

endmodule

// File: rtl/pipe3_stall_chk.sv
module pipe3_stall_chk #(
    parameter int TAG_W   = 8,
    parameter int MAX_LAT = 64,
    localparam int CNT_W  = $clog2(MAX_LAT)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             in_ready,
    input logic             busy,
    input logic             ret_valid,
    input logic [TAG_W-1:0] ret_tag
);

    // Length of the current run of busy cycles, before this cycle.
    logic [CNT_W:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + (CNT_W+1)'(1);
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !ret_valid));

    a_r2_hold_fetch_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    a_r2_flush_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
        flush |-> !in_ready);

    a_r4_busy_excl_retire: assert property (@(posedge clk) disable iff (rst)
        !(busy && ret_valid));

    a_r4_busy_run_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < (CNT_W+1)'(MAX_LAT - 1)));

    a_r7_flush_empties_ex: assert property (@(posedge clk) disable iff (rst)
        (flush && !busy) |=> (!busy && !ret_valid));

    a_r8_tag_stable_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ret_tag));

endmodule

bind pipe3_stall_ctrl pipe3_stall_chk #(
    .TAG_W   (TAG_W),
    .MAX_LAT (MAX_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_ready  (in_ready),
    .busy      (busy),
    .ret_valid (ret_valid),
    .ret_tag   (ret_tag)
);

// File: tb/tb_pipe3_stall_ctrl.sv
module tb_pipe3_stall_ctrl;

    localparam int TAG_W   = 8;
    localparam int MAX_LAT = 64;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [TAG_W-1:0] in_tag = '0;
    logic             in_multi = 1'b0;
    logic [LAT_W-1:0] in_lat = '0;
    logic             flush = 1'b0;
    logic             busy;
    logic             ret_valid;
    logic [TAG_W-1:0] ret_tag;

    pipe3_stall_ctrl #(.TAG_W(TAG_W), .MAX_LAT(MAX_LAT)) dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_tag (in_tag), .in_multi (in_multi), .in_lat (in_lat),
        .flush (flush), .busy (busy), .ret_valid (ret_valid), .ret_tag (ret_tag)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int ret_cyc [256];
    int ret_cnt [256];
    int log_tag [64];
    int exp_tag [64];
    int n_log = 0;
    int n_exp = 0;
    int busy_cycles = 0;
    int ready_in_busy = 0;
    int tag_moves = 0;
    logic             prev_busy = 1'b0;
    logic [TAG_W-1:0] prev_tag = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: samples outputs at the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (ret_valid) begin
                ret_cyc[ret_tag] = cyc;
                ret_cnt[ret_tag] = ret_cnt[ret_tag] + 1;
                if (n_log < 64) log_tag[n_log] = int'(ret_tag);
                n_log = n_log + 1;
            end
            if (busy) busy_cycles = busy_cycles + 1;
            if (busy && in_ready) ready_in_busy = ready_in_busy + 1;
            if (busy && prev_busy && ret_tag != prev_tag) tag_moves = tag_moves + 1;
            if (prev_busy && ret_tag != prev_tag) tag_moves = tag_moves + 1;
        end
        prev_busy = busy;
        prev_tag  = ret_tag;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        if (cyc == 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Offer one instruction; returns the cycle index right after its accept edge.
    task automatic issue(int tag, bit multi, int lat, bit keep, output int acc);
        in_valid = 1'b1;
        in_tag   = TAG_W'(tag);
        in_multi = multi;
        in_lat   = LAT_W'(lat);
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        if (keep) begin
            exp_tag[n_exp] = tag;
            n_exp = n_exp + 1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 ret_valid in reset", int'(ret_valid), 0);
        chk("R1 in_ready in reset", int'(in_ready), 1);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic t_single_stream();
        int a1, a2, a3;
        issue(1, 1'b0, 0, 1'b1, a1);
        issue(2, 1'b0, 0, 1'b1, a2);
        issue(3, 1'b0, 0, 1'b1, a3);
        idle(5);
        chk("R2 back-to-back accept", a2 - a1, 1);
        chk("R3 tag1 retire cycle", ret_cyc[1], a1 + 2);
        chk("R3 tag2 retire cycle", ret_cyc[2], a2 + 2);
        chk("R3 tag3 retire cycle", ret_cyc[3], a3 + 2);
    endtask

    task automatic t_multi_then_indep();
        int ax, ay, az;
        busy_cycles = 0;
        issue(10, 1'b1, 5, 1'b1, ax);
        issue(11, 1'b0, 0, 1'b1, ay);
        issue(12, 1'b0, 0, 1'b1, az);
        idle(12);
        chk("R4 multi L=5 retire", ret_cyc[10], ax + 6);
        chk("R4 busy cycles L=5", busy_cycles, 4);
        chk("R6 independent follower retire", ret_cyc[11], ret_cyc[10] + 1);
        chk("R6 third instruction retire", ret_cyc[12], ret_cyc[10] + 2);
    endtask

    task automatic t_latency_field();
        int a;
        busy_cycles = 0;
        issue(20, 1'b0, 40, 1'b1, a);
        idle(5);
        chk("R5 lat ignored single retire", ret_cyc[20], a + 2);
        chk("R5 lat ignored busy", busy_cycles, 0);
        issue(21, 1'b1, 0, 1'b1, a);
        idle(5);
        chk("R5 lat zero as one", ret_cyc[21], a + 2);
        busy_cycles = 0;
        issue(22, 1'b1, 100, 1'b1, a);
        idle(70);
        chk("R5 saturated retire", ret_cyc[22], a + MAX_LAT + 1);
        chk("R4 saturated busy cycles", busy_cycles, MAX_LAT - 1);
        busy_cycles = 0;
        issue(23, 1'b1, MAX_LAT, 1'b1, a);
        idle(70);
        chk("R4 max latency retire", ret_cyc[23], a + MAX_LAT + 1);
    endtask

    task automatic t_flush();
        int ax, ay, az, an;
        issue(30, 1'b1, 6, 1'b1, ax);
        issue(31, 1'b0, 0, 1'b0, ay);
        issue(32, 1'b0, 0, 1'b0, az);
        chk("R7 busy before flush", int'(busy), 1);
        flush = 1'b1;
        @(negedge clk);
        #1;
        flush = 1'b0;
        idle(12);
        chk("R7 executing op keeps timing", ret_cyc[30], ax + 7);
        chk("R7 flushed op-fetch never retires", ret_cnt[31], 0);
        chk("R7 flushed fetch never retires", ret_cnt[32], 0);
        // Flush with execute idle and an instruction offered.
        in_valid = 1'b1;
        in_tag   = TAG_W'(33);
        in_multi = 1'b0;
        flush    = 1'b1;
        #1;
        chk("R2 in_ready low under flush", int'(in_ready), 0);
        @(negedge clk);
        #1;
        flush    = 1'b0;
        in_valid = 1'b0;
        chk("R7 execute empty after flush", int'(busy) + int'(ret_valid), 0);
        idle(6);
        chk("R7 offer during flush dropped", ret_cnt[33], 0);
        issue(34, 1'b0, 0, 1'b1, an);
        idle(5);
        chk("R3 recovery after flush", ret_cyc[34], an + 2);
    endtask

    task automatic t_order();
        chk("R8 retire count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < 64; i++) begin
            chk("R8 retire order", log_tag[i], exp_tag[i]);
            chk("R8 retired once", ret_cnt[exp_tag[i]], 1);
        end
        chk("R8 tag steady while busy", tag_moves, 0);
        chk("R2 ready while busy", ready_in_busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ret_cyc[i] = -1;
            ret_cnt[i] = 0;
        end
        t_reset();
        t_single_stream();
        t_multi_then_indep();
        t_latency_field();
        t_flush();
        t_order();
        summary();
        $finish;
    end

endmodule